// File: doc/BRIEF.md
# Two-Array First-Level Translation Cache

This block is a small first-level translation cache that sits in front of a larger second-level TLB. A requester presents an effective page number. Two arrays search that page number in the same cycle, and the real page number comes back one clock later. The first array has four fully associative entries, and each entry may cover a page of any supported size. The second array holds only 4 KB pages and is organised as a set-associative array with four ways.

When both arrays miss, the block raises `busy` and sends a request for the page to the second level over a valid/ready handshake. It then waits for the answer. If the second level hits, the block returns the translation and installs it. The array that receives the new entry is chosen by the second-level array that produced the hit. If the second level misses as well, the block returns an error flag and installs nothing.

Each array, or each set of the 4 KB array, replaces its least recently used entry. The second level reports every write or invalidation of its own entries to this block. The block clears each local entry that the report covers, so its contents always stay a subset of the second level.

Top module: `utlb_l1`

## Requirements
- R1: After reset every entry of both arrays is invalid, `busy`, `out_valid` and `rf_req_valid` are 0, and the first lookup of any page misses.
- R2: A lookup accepted while `busy` is 0 that hits in either array sets `out_valid` with `out_err`=0 and the translated page on `out_rpn` in the next cycle. It raises no refill request and leaves `busy` at 0.
- R3: A variable-page entry with size code s covers 4^s pages of 4 KB, for s from 0 to 8. Its match ignores the low 2·s bits of the page number, and its result takes those low bits from the lookup and the remaining bits from the entry.
- R4: In the 4 KB array the low log2(SETS) page-number bits select the set. All four ways of that set are compared on the full page number.
- R5: A miss in both arrays raises `busy` and `rf_req_valid` in the next cycle with the page on `rf_req_epn`. Both stay unchanged until `rf_req_ready`. `rf_rsp_ready` is then held until the response arrives. Lookups presented while `busy` is 1 are ignored.
- R6: A response with `rf_rsp_hit`=1 sets `out_valid` with the translation in the next cycle, and `busy` falls in that same cycle. With `rf_rsp_src`=1 the entry goes to the variable-page array, using size code `rf_rsp_size`. With `rf_rsp_src`=0 it goes to the 4 KB array and the size is ignored. A later lookup of the page then hits.
- R7: A response with `rf_rsp_hit`=0 sets `out_valid` and `out_err` together, with `out_rpn`=0. Nothing is installed, so the same page misses again.
- R8: When the variable-page array fills, it uses the lowest-numbered invalid entry if one exists. Otherwise it replaces the entry that was least recently hit or filled.
- R9: The 4 KB array applies the same replacement rule inside each set, and each set's order is independent of the other sets.
- R10: A single invalidation (`inv_all`=0) targets the array named by `inv_src` (1 = variable-page, 0 = 4 KB) and leaves the other array untouched. In the variable-page array it clears every entry whose page overlaps the page at `inv_epn` with size code `inv_size`. In the 4 KB array it clears the entry whose page number equals `inv_epn`.
- R11: An invalidation with `inv_all`=1 clears every entry of the array named by `inv_src` and leaves the other array intact.
- R12: If any invalidation occurs in the same cycle as the response handshake, the response is still delivered but is not installed.
- R13: When both arrays hit, the variable-page array supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_epn | input | PN_W | Effective page number to translate |
| busy | output | 1 | Refill in progress; lookups ignored |
| out_valid | output | 1 | Result pulse |
| out_err | output | 1 | Second level missed too |
| out_rpn | output | PN_W | Real page number of the result |
| rf_req_valid | output | 1 | Refill request to the second level |
| rf_req_ready | input | 1 | Second level accepts the request |
| rf_req_epn | output | PN_W | Page number being refilled |
| rf_rsp_valid | input | 1 | Refill response present |
| rf_rsp_ready | output | 1 | Block waits for the response |
| rf_rsp_hit | input | 1 | Second level found a translation |
| rf_rsp_src | input | 1 | 1 = variable-page array hit, 0 = 4 KB array hit |
| rf_rsp_size | input | SZ_W | Page size code (variable-page source) |
| rf_rsp_rpn | input | PN_W | Real page number from the second level |
| inv_valid | input | 1 | Second-level entry written or invalidated |
| inv_all | input | 1 | Clear the whole target array |
| inv_src | input | 1 | Target array: 1 = variable-page, 0 = 4 KB |
| inv_epn | input | PN_W | Page number of the affected entry |
| inv_size | input | SZ_W | Size code of the affected entry |

## Verification
A corrupted replacement order stays hidden until a set or the variable-page array is full. It appears only at the next fill: a recently used page then misses, or a stale page keeps hitting. The bench therefore fills each group, touches the entries in a known order, refills, and probes every way. A missed invalidation shows on the very next lookup of that page as a hit where a refill request was expected. A mask or size error shows as a wrong `out_rpn` one cycle after the lookup, so the bench checks every size code at both edges of the page and just beyond it.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

    localparam int SZ_W  = 4;
    localparam int NWAY  = 4;
    localparam int AGE_W = 2;

    typedef logic [AGE_W-1:0]  age_t;
    typedef age_t [NWAY-1:0]   age_vec_t;

    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} fsm_e;

    // Ones in the low 2*s bits: the offset part of a page of 4^s small pages.
    function automatic logic [31:0] page_mask(logic [SZ_W-1:0] s);
        logic [31:0] m;
        for (int b = 0; b < 32; b++) m[b] = (b < 2 * int'(s));
        return m;
    endfunction

    function automatic age_vec_t age_init();
        age_vec_t a;
        for (int i = 0; i < NWAY; i++) a[i] = age_t'(i);
        return a;
    endfunction

    // Make way w the youngest; entries younger than it grow one step older.
    function automatic age_vec_t age_touch(age_vec_t a, logic [1:0] w);
        age_vec_t r;
        for (int i = 0; i < NWAY; i++) begin
            if (2'(i) == w)       r[i] = '0;
            else if (a[i] < a[w]) r[i] = a[i] + age_t'(1);
            else                  r[i] = a[i];
        end
        return r;
    endfunction

    // Lowest free way first, otherwise the oldest way.
    function automatic logic [1:0] pick_victim(logic [NWAY-1:0] vld, age_vec_t a);
        logic [1:0] r;
        logic       found;
        r     = '0;
        found = 1'b0;
        for (int i = 0; i < NWAY; i++) begin
            if (!vld[i] && !found) begin
                r     = 2'(i);
                found = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < NWAY; i++) begin
                if (a[i] == age_t'(NWAY - 1)) r = 2'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/utlb_vpa.sv
module utlb_vpa import utlb_pkg::*; #(
    parameter int PN_W = 20
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lk_en,
    input  logic [PN_W-1:0] lk_epn,
    output logic            hit,
    output logic [PN_W-1:0] hit_rpn,
    input  logic            fill_en,
    input  logic [PN_W-1:0] fill_epn,
    input  logic [PN_W-1:0] fill_rpn,
    input  logic [SZ_W-1:0] fill_sz,
    input  logic            inv_en,
    input  logic            inv_all,
    input  logic [PN_W-1:0] inv_epn,
    input  logic [SZ_W-1:0] inv_sz
);
    typedef logic [PN_W-1:0] pn_t;
    typedef struct packed {
        logic            vld;
        logic [SZ_W-1:0] sz;
        pn_t             epn;
        pn_t             rpn;
    } ventry_t;

    ventry_t        ent_q [NWAY];
    age_vec_t       age_q;
    pn_t            msk   [NWAY];
    logic [NWAY-1:0] match;
    logic [NWAY-1:0] vld;
    logic [1:0]     hit_way;
    logic [1:0]     victim;
    pn_t            fmsk;
    pn_t            imsk;

    always_comb begin
        hit     = 1'b0;
        hit_rpn = '0;
        hit_way = '0;
        for (int i = 0; i < NWAY; i++) begin
            msk[i]   = pn_t'(page_mask(ent_q[i].sz));
            vld[i]   = ent_q[i].vld;
            match[i] = ent_q[i].vld && (((ent_q[i].epn ^ lk_epn) & ~msk[i]) == '0);
            if (match[i]) begin
                hit     = 1'b1;
                hit_rpn = (ent_q[i].rpn & ~msk[i]) | (lk_epn & msk[i]);
                hit_way = 2'(i);
            end
        end
        victim = pick_victim(vld, age_q);
        fmsk   = pn_t'(page_mask(fill_sz));
        imsk   = pn_t'(page_mask(inv_sz));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NWAY; i++) ent_q[i] <= '0;
            age_q <= age_init();
        end else begin
            if (lk_en && hit) begin
                age_q <= age_touch(age_q, hit_way);
            end else if (fill_en) begin
                ent_q[victim] <= '{vld: 1'b1, sz: fill_sz,
                                   epn: fill_epn & ~fmsk, rpn: fill_rpn & ~fmsk};
                age_q <= age_touch(age_q, victim);
            end
            if (inv_en) begin
                for (int i = 0; i < NWAY; i++) begin
                    if (inv_all || (((ent_q[i].epn ^ inv_epn) & ~(msk[i] | imsk)) == '0))
                        ent_q[i].vld <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/utlb_spa.sv
module utlb_spa import utlb_pkg::*; #(
    parameter int PN_W = 20,
    parameter int SETS = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lk_en,
    input  logic [PN_W-1:0] lk_epn,
    output logic            hit,
    output logic [PN_W-1:0] hit_rpn,
    input  logic            fill_en,
    input  logic [PN_W-1:0] fill_epn,
    input  logic [PN_W-1:0] fill_rpn,
    input  logic            inv_en,
    input  logic            inv_all,
    input  logic [PN_W-1:0] inv_epn
);
    localparam int IDX_W = $clog2(SETS);

    typedef logic [PN_W-1:0] pn_t;
    typedef struct packed {
        logic vld;
        pn_t  epn;
        pn_t  rpn;
    } sentry_t;

    sentry_t          ent_q [SETS][NWAY];
    age_vec_t         age_q [SETS];
    logic [IDX_W-1:0] lk_idx, fill_idx, inv_idx;
    logic [NWAY-1:0]  fvld;
    logic [1:0]       hit_way;
    logic [1:0]       victim;

    assign lk_idx   = lk_epn[IDX_W-1:0];
    assign fill_idx = fill_epn[IDX_W-1:0];
    assign inv_idx  = inv_epn[IDX_W-1:0];

    always_comb begin
        hit     = 1'b0;
        hit_rpn = '0;
        hit_way = '0;
        for (int w = 0; w < NWAY; w++) begin
            fvld[w] = ent_q[fill_idx][w].vld;
            if (ent_q[lk_idx][w].vld && ent_q[lk_idx][w].epn == lk_epn) begin
                hit     = 1'b1;
                hit_rpn = ent_q[lk_idx][w].rpn;
                hit_way = 2'(w);
            end
        end
        victim = pick_victim(fvld, age_q[fill_idx]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < NWAY; w++) ent_q[s][w] <= '0;
                age_q[s] <= age_init();
            end
        end else begin
            if (lk_en && hit) begin
                age_q[lk_idx] <= age_touch(age_q[lk_idx], hit_way);
            end else if (fill_en) begin
                ent_q[fill_idx][victim] <= '{vld: 1'b1, epn: fill_epn, rpn: fill_rpn};
                age_q[fill_idx] <= age_touch(age_q[fill_idx], victim);
            end
            if (inv_en) begin
                if (inv_all) begin
                    for (int s = 0; s < SETS; s++)
                        for (int w = 0; w < NWAY; w++) ent_q[s][w].vld <= 1'b0;
                end else begin
                    for (int w = 0; w < NWAY; w++)
                        if (ent_q[inv_idx][w].epn == inv_epn) ent_q[inv_idx][w].vld <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/utlb_l1.sv
module utlb_l1 import utlb_pkg::*; #(
    parameter int PN_W = 20,
    parameter int SETS = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lk_valid,
    input  logic [PN_W-1:0] lk_epn,
    output logic            busy,
    output logic            out_valid,
    output logic            out_err,
    output logic [PN_W-1:0] out_rpn,
    output logic            rf_req_valid,
    input  logic            rf_req_ready,
    output logic [PN_W-1:0] rf_req_epn,
    input  logic            rf_rsp_valid,
    output logic            rf_rsp_ready,
    input  logic            rf_rsp_hit,
    input  logic            rf_rsp_src,
    input  logic [SZ_W-1:0] rf_rsp_size,
    input  logic [PN_W-1:0] rf_rsp_rpn,
    input  logic            inv_valid,
    input  logic            inv_all,
    input  logic            inv_src,
    input  logic [PN_W-1:0] inv_epn,
    input  logic [SZ_W-1:0] inv_size
);
    typedef logic [PN_W-1:0] pn_t;

    fsm_e            st_q;
    pn_t             pend_q;
    logic            look;
    logic            v_hit, s_hit, any_hit;
    pn_t             v_rpn, s_rpn;
    logic            rsp_fire, fill_ok;
    logic [SZ_W-1:0] rsp_sz;
    pn_t             rsp_msk, rsp_pn;

    assign look     = lk_valid && (st_q == ST_IDLE);
    assign any_hit  = v_hit || s_hit;
    assign rsp_fire = (st_q == ST_WAIT) && rf_rsp_valid;
    assign fill_ok  = rsp_fire && rf_rsp_hit && !inv_valid;
    assign rsp_sz   = rf_rsp_src ? rf_rsp_size : '0;
    assign rsp_msk  = pn_t'(page_mask(rsp_sz));
    assign rsp_pn   = (rf_rsp_rpn & ~rsp_msk) | (pend_q & rsp_msk);

    assign busy         = (st_q != ST_IDLE);
    assign rf_req_valid = (st_q == ST_REQ);
    assign rf_req_epn   = pend_q;
    assign rf_rsp_ready = (st_q == ST_WAIT);

    utlb_vpa #(.PN_W(PN_W)) u_vpa (
        .clk      (clk),
        .rst      (rst),
        .lk_en    (look),
        .lk_epn   (lk_epn),
        .hit      (v_hit),
        .hit_rpn  (v_rpn),
        .fill_en  (fill_ok && rf_rsp_src),
        .fill_epn (pend_q),
        .fill_rpn (rf_rsp_rpn),
        .fill_sz  (rf_rsp_size),
        .inv_en   (inv_valid && inv_src),
        .inv_all  (inv_all),
        .inv_epn  (inv_epn),
        .inv_sz   (inv_size)
    );

    utlb_spa #(.PN_W(PN_W), .SETS(SETS)) u_spa (
        .clk      (clk),
        .rst      (rst),
        .lk_en    (look),
        .lk_epn   (lk_epn),
        .hit      (s_hit),
        .hit_rpn  (s_rpn),
        .fill_en  (fill_ok && !rf_rsp_src),
        .fill_epn (pend_q),
        .fill_rpn (rf_rsp_rpn),
        .inv_en   (inv_valid && !inv_src),
        .inv_all  (inv_all),
        .inv_epn  (inv_epn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            pend_q    <= '0;
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            out_rpn   <= '0;
        end else begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (lk_valid) begin
                        if (any_hit) begin
                            out_valid <= 1'b1;
                            out_rpn   <= v_hit ? v_rpn : s_rpn;
                        end else begin
                            pend_q <= lk_epn;
                            st_q   <= ST_REQ;
                        end
                    end
                end
                ST_REQ: begin
                    if (rf_req_ready) st_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (rf_rsp_valid) begin
                        out_valid <= 1'b1;
                        out_err   <= !rf_rsp_hit;
                        out_rpn   <= rf_rsp_hit ? rsp_pn : '0;
                        st_q      <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/utlb_l1_chk.sv
module utlb_l1_chk #(
    parameter int PN_W = 20
) (
    input logic            clk,
    input logic            rst,
    input logic            lk_valid,
    input logic            any_hit,
    input logic            busy,
    input logic            out_valid,
    input logic            out_err,
    input logic            rf_req_valid,
    input logic            rf_req_ready,
    input logic [PN_W-1:0] rf_req_epn,
    input logic            rf_rsp_valid,
    input logic            rf_rsp_ready
);
    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        lk_valid && !busy && any_hit |=> out_valid && !out_err && !busy); // R2
    AST_OUT_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !busy); // R2
    AST_MISS_REQUESTS: assert property (@(posedge clk) disable iff (rst)
        lk_valid && !busy && !any_hit |=> busy && rf_req_valid && !out_valid); // R5
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        rf_req_valid && !rf_req_ready |=> rf_req_valid && $stable(rf_req_epn)); // R5
    AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        rf_req_valid |-> busy && !rf_rsp_ready); // R5
    AST_RSP_COMPLETES: assert property (@(posedge clk) disable iff (rst)
        rf_rsp_valid && rf_rsp_ready |=> out_valid && !busy); // R6
    AST_ERR_HAS_VALID: assert property (@(posedge clk) disable iff (rst)
        out_err |-> out_valid); // R7
endmodule

bind utlb_l1 utlb_l1_chk #(.PN_W(PN_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .lk_valid     (lk_valid),
    .any_hit      (any_hit),
    .busy         (busy),
    .out_valid    (out_valid),
    .out_err      (out_err),
    .rf_req_valid (rf_req_valid),
    .rf_req_ready (rf_req_ready),
    .rf_req_epn   (rf_req_epn),
    .rf_rsp_valid (rf_rsp_valid),
    .rf_rsp_ready (rf_rsp_ready)
);

// File: tb/utlb_l1_bench.sv
module utlb_l1_bench;
    localparam int CLK_P = 10;
    localparam int PN_W  = 20;
    localparam int SETS  = 16;
    localparam int SZ_W  = 4;

    typedef logic [PN_W-1:0] pn_t;

    logic            clk = 1'b0;
    logic            rst;
    logic            lk_valid, rf_req_ready, rf_rsp_valid, rf_rsp_hit, rf_rsp_src;
    logic            inv_valid, inv_all, inv_src;
    pn_t             lk_epn, rf_rsp_rpn, inv_epn;
    logic [SZ_W-1:0] rf_rsp_size, inv_size;
    logic            busy, out_valid, out_err, rf_req_valid, rf_rsp_ready;
    pn_t             out_rpn, rf_req_epn;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    utlb_l1 #(.PN_W(PN_W), .SETS(SETS)) u_utlb_l1 (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_epn(lk_epn), .busy(busy),
        .out_valid(out_valid), .out_err(out_err), .out_rpn(out_rpn),
        .rf_req_valid(rf_req_valid), .rf_req_ready(rf_req_ready), .rf_req_epn(rf_req_epn),
        .rf_rsp_valid(rf_rsp_valid), .rf_rsp_ready(rf_rsp_ready), .rf_rsp_hit(rf_rsp_hit),
        .rf_rsp_src(rf_rsp_src), .rf_rsp_size(rf_rsp_size), .rf_rsp_rpn(rf_rsp_rpn),
        .inv_valid(inv_valid), .inv_all(inv_all), .inv_src(inv_src),
        .inv_epn(inv_epn), .inv_size(inv_size)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic pn_t bmask(int s);
        return pn_t'((64'd1 << (2 * s)) - 64'd1);
    endfunction

    task automatic lookup_hit(pn_t epn, pn_t exp, string req);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_epn   = epn;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(req, {8'h0, out_valid, out_err, busy, rf_req_valid, out_rpn},
                 {8'h0, 1'b1, 1'b0, 1'b0, 1'b0, exp});
    endtask

    task automatic lookup_refill(pn_t epn, bit l2hit, bit src, int sz, pn_t l2rpn,
                                 bit inv_same, string req);
        pn_t m;
        pn_t exp;
        @(negedge clk);
        lk_valid = 1'b1;
        lk_epn   = epn;
        @(negedge clk);
        lk_epn = ~epn;  // presented while busy: must be ignored (R5)
        chk({req, " R5 req"}, {9'h0, busy, rf_req_valid, out_valid, rf_req_epn},
                              {9'h0, 1'b1, 1'b1, 1'b0, epn});
        @(negedge clk);
        lk_valid = 1'b0;
        chk({req, " R5 hold"}, {9'h0, busy, rf_req_valid, out_valid, rf_req_epn},
                               {9'h0, 1'b1, 1'b1, 1'b0, epn});
        rf_req_ready = 1'b1;
        @(negedge clk);
        rf_req_ready = 1'b0;
        chk({req, " R5 wait"}, {28'h0, rf_rsp_ready, rf_req_valid, busy, out_valid},
                               {28'h0, 4'b1010});
        rf_rsp_valid = 1'b1;
        rf_rsp_hit   = l2hit;
        rf_rsp_src   = src;
        rf_rsp_size  = SZ_W'(sz);
        rf_rsp_rpn   = l2rpn;
        if (inv_same) begin
            inv_valid = 1'b1;
            inv_all   = 1'b0;
            inv_src   = 1'b1;
            inv_epn   = 20'hFFFF0;
            inv_size  = '0;
        end
        @(negedge clk);
        rf_rsp_valid = 1'b0;
        inv_valid    = 1'b0;
        m   = src ? bmask(sz) : '0;
        exp = l2hit ? ((l2rpn & ~m) | (epn & m)) : '0;
        chk({req, " result"}, {9'h0, out_valid, out_err, busy, out_rpn},
                              {9'h0, 1'b1, !l2hit, 1'b0, exp});
    endtask

    task automatic miss_err(pn_t epn, string req);
        lookup_refill(epn, 1'b0, 1'b0, 0, '0, 1'b0, req);
    endtask

    task automatic do_inv(bit src, bit all, pn_t epn, int sz);
        @(negedge clk);
        inv_valid = 1'b1;
        inv_src   = src;
        inv_all   = all;
        inv_epn   = epn;
        inv_size  = SZ_W'(sz);
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    function automatic pn_t s_epn(int set, int w);
        return pn_t'(((w + 1) << 12) | (8'h35 << 4) | set);
    endfunction

    function automatic pn_t s_rpn(pn_t e);
        return e ^ 20'h5A5A0;
    endfunction

    initial begin
        rst = 1'b1; lk_valid = 0; lk_epn = '0; rf_req_ready = 0; rf_rsp_valid = 0;
        rf_rsp_hit = 0; rf_rsp_src = 0; rf_rsp_size = '0; rf_rsp_rpn = '0;
        inv_valid = 0; inv_all = 0; inv_src = 0; inv_epn = '0; inv_size = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: quiet outputs, empty arrays
        chk("R1 reset outputs", {28'h0, busy, out_valid, rf_req_valid, rf_rsp_ready}, 32'h0);
        for (int i = 0; i < 8; i++) miss_err(pn_t'(i * 32'h2357), "R1 empty");

        // R3 / R6 / R7: every size code in the variable-page array
        for (int s = 0; s <= 8; s++) begin
            pn_t base, l2r, outside, off;
            do_inv(1'b1, 1'b1, '0, 0);
            base    = pn_t'(32'hB6D2C) & ~bmask(s);
            l2r     = pn_t'(32'h41E77 * (s + 1));
            off     = base | (bmask(s) & 20'h5A5A5);
            outside = base + pn_t'(64'd1 << (2 * s));
            lookup_refill(off, 1'b1, 1'b1, s, l2r, 1'b0, "R6 R3 var fill");
            lookup_hit(base, (l2r & ~bmask(s)), "R3 low edge");
            lookup_hit(base | bmask(s), (l2r & ~bmask(s)) | bmask(s), "R3 high edge");
            miss_err(outside, "R3 outside R7");
            miss_err(outside, "R7 no fill");
        end

        // R4 / R6: fill every way of every set of the 4 KB array
        do_inv(1'b1, 1'b1, '0, 0);
        for (int set = 0; set < SETS; set++)
            for (int w = 0; w < 4; w++)
                lookup_refill(s_epn(set, w), 1'b1, 1'b0, 5, s_rpn(s_epn(set, w)), 1'b0, "R6 4K fill");
        for (int set = 0; set < SETS; set++)
            for (int w = 0; w < 4; w++)
                lookup_hit(s_epn(set, w), s_rpn(s_epn(set, w)), "R4 4K hit");

        // R9: per-set replacement; way 1 is oldest after touching 2,0,3
        for (int set = 0; set < SETS; set++) begin
            lookup_hit(s_epn(set, 2), s_rpn(s_epn(set, 2)), "R9 touch");
            lookup_hit(s_epn(set, 0), s_rpn(s_epn(set, 0)), "R9 touch");
            lookup_hit(s_epn(set, 3), s_rpn(s_epn(set, 3)), "R9 touch");
            lookup_refill(s_epn(set, 4), 1'b1, 1'b0, 0, s_rpn(s_epn(set, 4)), 1'b0, "R9 fill");
            miss_err(s_epn(set, 1), "R9 victim gone");
            lookup_hit(s_epn(set, 0), s_rpn(s_epn(set, 0)), "R9 kept");
            lookup_hit(s_epn(set, 2), s_rpn(s_epn(set, 2)), "R9 kept");
            lookup_hit(s_epn(set, 3), s_rpn(s_epn(set, 3)), "R9 kept");
            lookup_hit(s_epn(set, 4), s_rpn(s_epn(set, 4)), "R9 new");
        end
        for (int set = 0; set < SETS; set++)
            lookup_hit(s_epn(set, 4), s_rpn(s_epn(set, 4)), "R9 sets independent");

        // R8: variable-page replacement order and free-entry preference
        begin
            pn_t v [6];
            for (int i = 0; i < 6; i++) v[i] = pn_t'(32'hE0000 + i * 32'h100);
            for (int i = 0; i < 4; i++) lookup_refill(v[i], 1'b1, 1'b1, 0, v[i] ^ 20'h0F0F0, 1'b0, "R8 fill");
            lookup_hit(v[1], v[1] ^ 20'h0F0F0, "R8 touch");
            lookup_hit(v[0], v[0] ^ 20'h0F0F0, "R8 touch");
            lookup_refill(v[4], 1'b1, 1'b1, 0, v[4] ^ 20'h0F0F0, 1'b0, "R8 fill full");
            miss_err(v[2], "R8 oldest replaced");
            lookup_hit(v[0], v[0] ^ 20'h0F0F0, "R8 kept");
            lookup_hit(v[1], v[1] ^ 20'h0F0F0, "R8 kept");
            lookup_hit(v[3], v[3] ^ 20'h0F0F0, "R8 kept");
            lookup_hit(v[4], v[4] ^ 20'h0F0F0, "R8 kept");
            do_inv(1'b1, 1'b0, v[3], 0);
            miss_err(v[3], "R10 var single");
            lookup_refill(v[5], 1'b1, 1'b1, 0, v[5] ^ 20'h0F0F0, 1'b0, "R8 fill free");
            lookup_hit(v[0], v[0] ^ 20'h0F0F0, "R8 free slot used");
            lookup_hit(v[1], v[1] ^ 20'h0F0F0, "R8 free slot used");
            lookup_hit(v[4], v[4] ^ 20'h0F0F0, "R8 free slot used");
            lookup_hit(v[5], v[5] ^ 20'h0F0F0, "R8 free slot used");
        end

        // R10: overlap invalidation and array selection
        do_inv(1'b1, 1'b1, '0, 0);
        lookup_refill(20'h70000, 1'b1, 1'b1, 2, 20'h2A5C0, 1'b0, "R10 big fill");
        do_inv(1'b1, 1'b0, 20'h7000B, 0);
        miss_err(20'h70000, "R10 overlap cleared");
        lookup_refill(20'h70000, 1'b1, 1'b1, 2, 20'h2A5C0, 1'b0, "R10 refill");
        do_inv(1'b1, 1'b0, 20'h70010, 0);
        lookup_hit(20'h70003, 20'h2A5C3, "R10 outside kept");
        do_inv(1'b0, 1'b0, 20'h70000, 0);
        lookup_hit(20'h70000, 20'h2A5C0, "R10 other array kept");
        do_inv(1'b0, 1'b0, s_epn(3, 0), 0);
        miss_err(s_epn(3, 0), "R10 4K single");
        lookup_hit(s_epn(3, 2), s_rpn(s_epn(3, 2)), "R10 4K neighbour");

        // R11: flash-clear only the named array
        do_inv(1'b0, 1'b1, '0, 0);
        miss_err(s_epn(5, 4), "R11 4K cleared");
        miss_err(s_epn(9, 0), "R11 4K cleared");
        lookup_hit(20'h70001, 20'h2A5C1, "R11 var intact");

        // R12: invalidation coinciding with response blocks the install
        do_inv(1'b1, 1'b1, '0, 0);
        lookup_refill(20'h31000, 1'b1, 1'b1, 0, 20'h12345, 1'b1, "R12 delivered");
        miss_err(20'h31000, "R12 not installed");

        // R13: variable-page array wins when both hit
        lookup_refill(20'h42003, 1'b1, 1'b0, 0, 20'h11111, 1'b0, "R13 4K fill");
        lookup_refill(20'h42001, 1'b1, 1'b1, 1, 20'h88880, 1'b0, "R13 var fill");
        lookup_hit(20'h42003, 20'h88883, "R13 priority");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule